// File: doc/BRIEF.md
# Banked Six-Channel Down-Counting Timer

This block is a memory-mapped timer with a bank of independent down-counters, six by default, each 32 bits wide. Each channel has three registers: a control word, a reload interval and a live count. Software can write the live count at any time, including while the channel is counting. Each channel steps down on a selected tick, divided by a power of two. When a channel expires it raises its own pending flag. It then either reloads from its interval and keeps counting, or stops.

All channels share one interrupt-enable register and one pending register. A pending bit is cleared by writing a one to it. The interrupt line is high while any channel is both pending and enabled. The bus side is a plain 32-bit port. Writes are captured on the clock edge while `wr_en` is high. Reads are combinational from `addr`.

Each channel runs a two-state machine. IDLE goes to RUN when a control write sets the start bit (transition *arm*). RUN goes to IDLE on a control write that clears the start bit (transition *halt*). RUN also goes to IDLE when the channel expires and is not set to continue (transition *finish*). RUN stays in RUN on an expiry that reloads (transition *wrap*).

Top module: `tick_bank_timer`

## Requirements
- R1: After reset, all registers read zero, `pend` is zero and `irq` is low.
- R2: Offset 0x00 holds the enable bits and offset 0x04 the pending bits, with bit n belonging to channel n and unused upper bits reading zero. Writing 1 to a pending bit clears it. Writing 0 leaves it as it was.
- R3: Channel n has its control register at 0x10+0x10*n, its interval at 0x14+0x10*n and its live count at 0x18+0x10*n. Control bits read back as written, with this layout:
  - bit 0: start; this bit reads back the channel's run state.
  - bit 1: reload.
  - bits 3:2: tick source.
  - bits 6:4: divider exponent k.
  - bit 7: single-shot.
- R4: A running channel with source 1 and k=0 decrements its count once per clock. The first decrement comes on the edge after the start write.
- R5: A divider exponent k makes the channel step once every 2^k source ticks. The divider restarts each time the channel is started.
- R6: A source value other than 1 steps the channel only on clocks where `tick_in` is high.
- R7: A step that finds the count at 1 or 0 is an expiry and sets the channel's pending bit. If reload is 1 and single-shot is 0, the count is loaded from the interval and the channel keeps running.
- R8: On an expiry with reload 0 or single-shot 1, the count becomes 0 and the start bit clears. No further expiry follows until the channel is started again.
- R9: A write to the live count of a running channel takes effect at once, and counting continues from the written value.
- R10: `irq` is high exactly when some channel is both pending and enabled.
- R11: Offsets that map to no register read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Alternate tick enable for channels whose source is not 1 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pend | output | 6 | Pending flag per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is a channel expiring while software writes to the same channel. Examples are a pending-bit clear landing on the same edge as the next step, and a live-count write landing while the divider is mid-period. The stimulus reaches these points by starting channels with tiny counts and intervals, then placing each bus write on a clock edge counted from the start write. It also checks that a channel which stopped itself shows its start bit cleared and stays at zero over several later cycles.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
    localparam int AW = 8;
    localparam logic [AW-1:0] IER_ADDR  = 8'h00;
    localparam logic [AW-1:0] PEND_ADDR = 8'h04;
    localparam logic [AW-1:0] CH_STRIDE = 8'h10;
    localparam logic [3:0]    CTRL_OFF  = 4'h0;
    localparam logic [3:0]    INTV_OFF  = 4'h4;
    localparam logic [3:0]    CUR_OFF   = 4'h8;
    localparam logic [1:0]    SRC_MAIN  = 2'd1;

    typedef enum logic {CH_IDLE, CH_RUN} ch_state_e;

    // control bits 7:1 in register order
    typedef struct packed {
        logic       single;
        logic [2:0] presc;
        logic [1:0] src;
        logic       reload;
    } ch_cfg_t;

    function automatic logic [AW-1:0] ch_addr(int idx, logic [3:0] off);
        return AW'((idx + 1) * 16) | {4'h0, off};
    endfunction
endpackage

// File: rtl/tbt_channel.sv
module tbt_channel
    import tbt_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_in,
    input  logic          wr_ctrl,
    input  logic          wr_intv,
    input  logic          wr_cur,
    input  logic [DW-1:0] wdata,
    output logic [7:0]    ctrl_rd,
    output logic [DW-1:0] intv_q,
    output logic [DW-1:0] cur_q,
    output logic          run,
    output logic          expire
);
    localparam int PCW = (1 << PW) - 1;

    ch_state_e      state_q, state_d;
    ch_cfg_t        cfg_q;
    logic [PCW-1:0] pcnt_q;
    logic [PCW-1:0] mask;
    logic           src_tick, step, hit, keep;

    assign src_tick = (cfg_q.src == SRC_MAIN) ? 1'b1 : tick_in;
    assign mask     = {PCW{1'b1}} >> (PW'(PCW) - cfg_q.presc);
    assign step     = (state_q == CH_RUN) && src_tick && ((pcnt_q & mask) == mask);
    assign hit      = step && (cur_q <= DW'(1));
    assign keep     = cfg_q.reload && !cfg_q.single;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (wr_ctrl && wdata[0]) state_d = CH_RUN;
            CH_RUN: begin
                if (wr_ctrl)            state_d = wdata[0] ? CH_RUN : CH_IDLE;
                else if (hit && !keep)  state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run     = (state_q == CH_RUN);
        expire  = hit;
        ctrl_rd = {cfg_q, run};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            intv_q <= '0;
            cur_q  <= '0;
            pcnt_q <= '0;
        end else begin
            if (wr_ctrl) cfg_q  <= wdata[7:1];
            if (wr_intv) intv_q <= wdata;
            if (wr_cur)       cur_q <= wdata;
            else if (hit)     cur_q <= keep ? intv_q : '0;
            else if (step)    cur_q <= cur_q - DW'(1);
            if (state_q != CH_RUN) pcnt_q <= '0;
            else if (src_tick)     pcnt_q <= pcnt_q + PCW'(1);
        end
    end
endmodule

// File: rtl/tbt_irq_regs.sv
module tbt_irq_regs #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_reg,
    input  logic           wr_pend,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] expire,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] pend_q,
    output logic           irq
);
    logic [NCH-1:0] clr;

    assign clr = wr_pend ? wbits : '0;
    assign irq = |(pend_q & en_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            if (wr_en_reg) en_q <= wbits;
            pend_q <= (pend_q & ~clr) | expire;
        end
    end
endmodule

// File: rtl/tick_bank_timer.sv
module tick_bank_timer
    import tbt_pkg::*;
#(
    parameter int NCH = 6,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_in,
    input  logic           wr_en,
    input  logic [7:0]     addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] pend,
    output logic           irq
);
    logic [NCH-1:0]         run_all, expire_all, en_bits;
    logic [NCH-1:0][DW-1:0] cur_all, intv_all;
    logic [NCH-1:0][7:0]    ctrl_all;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tbt_channel #(.DW(DW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_in (tick_in),
            .wr_ctrl (wr_en && addr == ch_addr(g, CTRL_OFF)),
            .wr_intv (wr_en && addr == ch_addr(g, INTV_OFF)),
            .wr_cur  (wr_en && addr == ch_addr(g, CUR_OFF)),
            .wdata   (wdata),
            .ctrl_rd (ctrl_all[g]),
            .intv_q  (intv_all[g]),
            .cur_q   (cur_all[g]),
            .run     (run_all[g]),
            .expire  (expire_all[g])
        );
    end

    tbt_irq_regs #(.NCH(NCH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_reg (wr_en && addr == IER_ADDR),
        .wr_pend   (wr_en && addr == PEND_ADDR),
        .wbits     (wdata[NCH-1:0]),
        .expire    (expire_all),
        .en_q      (en_bits),
        .pend_q    (pend),
        .irq       (irq)
    );

    always_comb begin
        rdata = '0;
        if (addr == IER_ADDR)  rdata[NCH-1:0] = en_bits;
        if (addr == PEND_ADDR) rdata[NCH-1:0] = pend;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ch_addr(i, CTRL_OFF)) rdata = DW'(ctrl_all[i]);
            if (addr == ch_addr(i, INTV_OFF)) rdata = intv_all[i];
            if (addr == ch_addr(i, CUR_OFF))  rdata = cur_all[i];
        end
    end
endmodule

// File: rtl/tick_bank_timer_chk.sv
module tick_bank_timer_chk
    import tbt_pkg::*;
#(
    parameter int NCH = 6,
    parameter int DW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [7:0]             addr,
    input logic [DW-1:0]          rdata,
    input logic [NCH-1:0]         pend,
    input logic                   irq,
    input logic [NCH-1:0]         run_all,
    input logic [NCH-1:0][DW-1:0] cur_all
);
    logic mapped;
    always_comb begin
        mapped = (addr == IER_ADDR) || (addr == PEND_ADDR);
        if (int'(addr[7:4]) >= 1 && int'(addr[7:4]) <= NCH &&
            (addr[3:0] == CTRL_OFF || addr[3:0] == INTV_OFF || addr[3:0] == CUR_OFF))
            mapped = 1'b1;
    end

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> rdata == '0);

    // R10
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend != '0);

    // R2
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && addr == PEND_ADDR) |-> (pend & $past(pend)) == $past(pend));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R7
        count_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cur_all[g] > $past(cur_all[g]) |->
                $past(wr_en && addr == ch_addr(g, CUR_OFF)) || $past(cur_all[g]) <= DW'(1));
        // R8
        restart_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_all[g]) |-> $past(wr_en && addr == ch_addr(g, CTRL_OFF)));
    end
endmodule

bind tick_bank_timer tick_bank_timer_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .pend    (pend),
    .irq     (irq),
    .run_all (run_all),
    .cur_all (cur_all)
);

// File: tb/tick_bank_timer_bench.sv
module tick_bank_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  pend;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    tick_bank_timer u_tick_bank_timer (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pend(pend), .irq(irq)
    );

    // {addr, write data, expected readback}
    localparam int NV = 9;
    localparam logic [71:0] VEC [NV] = '{
        {8'h00, 32'hFFFF_FFFF, 32'h0000_003F},  // R2
        {8'h00, 32'h0000_0008, 32'h0000_0008},  // R2
        {8'h24, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R3
        {8'h30, 32'h0000_00F6, 32'h0000_00F6},  // R3
        {8'h58, 32'h0000_0123, 32'h0000_0123},  // R3
        {8'h0C, 32'h0000_0055, 32'h0000_0000},  // R11
        {8'h80, 32'h0000_0001, 32'h0000_0000},  // R11
        {8'h1C, 32'h0000_00FF, 32'h0000_0000},  // R11
        {8'h04, 32'h0000_00FF, 32'h0000_0000}   // R2
    };

    // call at a falling edge; returns at the falling edge after the capture
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rchk("R1", 8'h00, 32'h0);
        rchk("R1", 8'h04, 32'h0);
        rchk("R1", 8'h10, 32'h0);
        rchk("R1", 8'h18, 32'h0);
        chk("R1", {31'h0, irq}, 32'h0);
        chk("R1", {26'h0, pend}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rchk("R2/R3/R11 vector", VEC[i][71:64], VEC[i][31:0]);
        end
        rchk("R11 enable untouched", 8'h00, 32'h8);

        // R4 main-clock counting on channel 0
        wr(8'h14, 32'd100);
        wr(8'h18, 32'd50);
        wr(8'h10, 32'h07);
        rchk("R4", 8'h18, 32'd50);
        repeat (10) @(negedge clk);
        rchk("R4", 8'h18, 32'd40);
        rchk("R3 start reads back", 8'h10, 32'h07);

        // R9 live-count write while running
        wr(8'h18, 32'd1000);
        rchk("R9", 8'h18, 32'd1000);
        repeat (4) @(negedge clk);
        rchk("R9", 8'h18, 32'd996);
        wr(8'h10, 32'h0);

        // R5 divide by 4 on channel 1
        wr(8'h28, 32'd20);
        wr(8'h20, 32'h25);
        repeat (3) @(negedge clk);
        rchk("R5", 8'h28, 32'd20);
        repeat (5) @(negedge clk);
        rchk("R5", 8'h28, 32'd18);
        wr(8'h20, 32'h0);

        // R6 alternate tick on channel 2
        wr(8'h38, 32'd30);
        wr(8'h30, 32'h03);
        repeat (5) @(negedge clk);
        rchk("R6", 8'h38, 32'd30);
        tick_in = 1'b1;
        repeat (3) @(negedge clk);
        tick_in = 1'b0;
        rchk("R6", 8'h38, 32'd27);
        wr(8'h30, 32'h0);

        // R7 continuous expiry on channel 3 (enabled)
        wr(8'h44, 32'd3);
        wr(8'h48, 32'd2);
        wr(8'h40, 32'h07);
        repeat (2) @(negedge clk);
        chk("R7 pending", {31'h0, pend[3]}, 32'h1);
        rchk("R7 reload", 8'h48, 32'd3);
        rchk("R7 still running", 8'h40, 32'h07);
        chk("R10 irq on", {31'h0, irq}, 32'h1);
        wr(8'h04, 32'h08);
        chk("R2 w1c", {31'h0, pend[3]}, 32'h0);
        chk("R10 irq off", {31'h0, irq}, 32'h0);
        rchk("R7 counts on", 8'h48, 32'd2);
        wr(8'h40, 32'h0);

        // R8 single-shot on channel 4
        wr(8'h54, 32'd5);
        wr(8'h58, 32'd1);
        wr(8'h50, 32'h87);
        @(negedge clk);
        chk("R8 pending", {31'h0, pend[4]}, 32'h1);
        rchk("R8 start cleared", 8'h50, 32'h86);
        rchk("R8 count zero", 8'h58, 32'd0);
        chk("R10 masked", {31'h0, irq}, 32'h0);
        wr(8'h04, 32'h10);
        repeat (5) @(negedge clk);
        chk("R8 no re-expiry", {31'h0, pend[4]}, 32'h0);
        rchk("R8 stays zero", 8'h58, 32'd0);
        rchk("R8 stays stopped", 8'h50, 32'h86);

        // R10 enable with pending
        wr(8'h04, 32'h3F);
        wr(8'h58, 32'd1);
        wr(8'h50, 32'h87);
        @(negedge clk);
        chk("R10 masked again", {31'h0, irq}, 32'h0);
        wr(8'h00, 32'h10);
        chk("R10 enabled", {31'h0, irq}, 32'h1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule